// File: doc/BRIEF.md
# Single-Cycle Integer Core for a Load/Store Instruction Subset

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction on every rising clock edge. It runs nine instructions: word load and store, register-register add, subtract, bitwise and, bitwise or, signed set-less-than, branch-if-equal and an absolute jump. The core holds the program counter, a 32-entry general register file, an ALU, a main decoder, an ALU-function decoder and the next-address selection. It also holds two separate word-addressed memories, one for instructions and one for data, each with `2**MEM_AW` words.

Memories are filled through a load port. The port writes one word per clock into the instruction store or into the data store, chosen by `ld_to_data`. It is normally used while the core is held in reset. A combinational debug port reads any data-memory word. The current program counter is visible on `pc`, which lets a testbench follow control flow.

Instruction layout: opcode in bits 31:26, first source `rs` in 25:21, second source/target `rt` in 20:16, destination `rd` in 15:11, function code in 5:0, 16-bit immediate in 15:0, and 26-bit jump word address in 25:0.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the program counter becomes 0 and every general register is cleared to 0.
- R2: Any instruction that is not a taken branch or a jump advances the program counter by 4.
- R3: With opcode 0, function codes 32, 34, 36 and 37 write rs+rt, rs-rt, rs AND rt and rs OR rt into register rd.
- R4: With opcode 0 and function code 42, register rd receives 1 when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R5: Opcode 35 loads the data word at byte address rs + sign-extended immediate into register rt (not rd). The word index is address bits [MEM_AW+1:2].
- R6: Opcode 43 stores register rt into the data word at byte address rs + sign-extended immediate, including negative offsets, and writes no register.
- R7: Opcode 4 sets the next PC to PC + 4 + (sign-extended immediate << 2) when rs equals rt, and to PC + 4 otherwise. Backward offsets are supported.
- R8: Opcode 2 sets the next PC to {PC[31:28], instruction[25:0], 2'b00}.
- R9: Register 0 always reads as 0. An instruction that targets register 0 leaves it at 0.
- R10: An opcode outside {0, 2, 4, 35, 43} writes neither a register nor data memory, and advances the PC by 4.
- R11: When `ld_we` is high at a rising edge, `ld_data` is written to word `ld_addr` of the data store if `ld_to_data` is 1, and of the instruction store if it is 0.
- R12: `dbg_data` shows data-memory word `dbg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Load-port write enable |
| ld_to_data | input | 1 | Load target: 1 data store, 0 instruction store |
| ld_addr | input | MEM_AW | Load-port word index |
| ld_data | input | 32 | Load-port write word |
| dbg_addr | input | MEM_AW | Debug read word index into data store |
| dbg_data | output | 32 | Debug read word |
| pc | output | 32 | Current program counter |

## Verification
The bench builds the core with its default `MEM_AW` of 6, which gives 64 words in each store. That is enough room for a 32-instruction program together with its operand and result area. With this size the data store can also be swept in full through the debug port on every clock. Byte addresses stay below 256, so a store through a negative offset from a loaded base and a backward branch are both reachable. The final self-loop leaves the jump's upper PC bits at zero.

// File: rtl/sc_pkg.sv
// Package for the single-cycle core: instruction opcodes, ALU
// function codes, function-field values and the decoded control bundle.
// Assumes the fixed 32-bit instruction layout described in the brief.
package sc_pkg;

    localparam int XLEN  = 32;
    localparam int RF_N  = 32;
    localparam int RF_AW = $clog2(RF_N);

    localparam logic [5:0] OPC_REG   = 6'd0;
    localparam logic [5:0] OPC_JUMP  = 6'd2;
    localparam logic [5:0] OPC_BREQ  = 6'd4;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    localparam logic [2:0] ALU_AND = 3'b000;
    localparam logic [2:0] ALU_OR  = 3'b001;
    localparam logic [2:0] ALU_ADD = 3'b010;
    localparam logic [2:0] ALU_SUB = 3'b110;
    localparam logic [2:0] ALU_SLT = 3'b111;

    localparam logic [1:0] AOP_ADD   = 2'b00;
    localparam logic [1:0] AOP_SUB   = 2'b01;
    localparam logic [1:0] AOP_FIELD = 2'b10;

    typedef struct packed {
        logic       dst_is_rd;
        logic       b_from_imm;
        logic       wb_from_mem;
        logic       reg_we;
        logic       mem_re;
        logic       mem_we;
        logic       is_branch;
        logic       is_jump;
        logic [1:0] alu_class;
    } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
// Main decoder: turns the 6-bit opcode into the control bundle.
// Assumes an unknown opcode must leave every enable low (acts as a no-op).
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    // Purpose: one row of control values per supported opcode.
    always_comb begin
        ctrl = '0;
        unique case (opcode)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_we    = 1'b1;
                ctrl.alu_class = AOP_FIELD;
            end
            OPC_LOAD: begin
                ctrl.b_from_imm  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_we      = 1'b1;
                ctrl.mem_re      = 1'b1;
                ctrl.alu_class   = AOP_ADD;
            end
            OPC_STORE: begin
                ctrl.b_from_imm = 1'b1;
                ctrl.mem_we     = 1'b1;
                ctrl.alu_class  = AOP_ADD;
            end
            OPC_BREQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_class = AOP_SUB;
            end
            OPC_JUMP: begin
                ctrl.is_jump = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/sc_alu_dec.sv
// ALU-function decoder: combines the 2-bit operation class with the
// function field to form the 3-bit ALU code. Assumes class 11 is unused
// and treats it, like unknown function codes, as addition.
module sc_alu_dec
    import sc_pkg::*;
(
    input  logic [1:0] alu_class,
    input  logic [5:0] funct,
    output logic [2:0] alu_code
);

    // Purpose: memory ops add, branches subtract, register ops follow funct.
    always_comb begin
        alu_code = ALU_ADD;
        if (alu_class == AOP_SUB) begin
            alu_code = ALU_SUB;
        end else if (alu_class == AOP_FIELD) begin
            case (funct)
                FN_ADD:  alu_code = ALU_ADD;
                FN_SUB:  alu_code = ALU_SUB;
                FN_AND:  alu_code = ALU_AND;
                FN_OR:   alu_code = ALU_OR;
                FN_SLT:  alu_code = ALU_SLT;
                default: alu_code = ALU_ADD;
            endcase
        end
    end

endmodule

// File: rtl/sc_regfile.sv
// General register file: two combinational read ports, one write port
// that updates on the rising edge when enabled. Entry 0 is hard zero.
// Assumes synchronous active-low reset clears every entry.
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [NREG];

    // Purpose: clear on reset, otherwise write one non-zero entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Purpose: read ports with entry 0 forced to zero.
    always_comb begin
        rd1 = (ra1 == '0) ? '0 : regs[ra1];
        rd2 = (ra2 == '0) ? '0 : regs[ra2];
    end

endmodule

// File: rtl/sc_alu.sv
// Integer ALU: and, or, add, subtract and signed set-less-than, plus a
// zero flag on the result. Assumes undefined codes produce zero.
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   code,
    output logic [W-1:0] y,
    output logic         zero
);

    // Purpose: select the operation named by the ALU code.
    always_comb begin
        case (code)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
        zero = (y == '0);
    end

endmodule

// File: rtl/sc_core.sv
// Single-cycle core top: PC, instruction and data stores, decoders,
// register file, ALU and next-PC selection. Every instruction retires on
// the rising edge that follows its fetch. Assumes the stores are filled
// through the load port, normally while rst_n is held low.
module sc_core
    import sc_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic              ld_to_data,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    input  logic [MEM_AW-1:0] dbg_addr,
    output logic [XLEN-1:0]   dbg_data,
    output logic [XLEN-1:0]   pc
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [XLEN-1:0]  imem [DEPTH];
    logic [XLEN-1:0]  dmem [DEPTH];
    logic [XLEN-1:0]  pc_q;
    logic [XLEN-1:0]  instr;
    logic [5:0]       opcode;
    logic [RF_AW-1:0] rs, rt, rd;
    logic [15:0]      imm;
    logic [XLEN-1:0]  imm_sx;
    ctrl_t            ctrl;
    logic [2:0]       alu_code;
    logic [XLEN-1:0]  rs_val, rt_val, alu_b, alu_y;
    logic             alu_zero;
    logic [RF_AW-1:0] rf_waddr;
    logic             rf_we;
    logic [XLEN-1:0]  rf_wdata;
    logic [MEM_AW-1:0] dm_idx;
    logic             dm_we;
    logic [XLEN-1:0]  dm_wdata;
    logic [XLEN-1:0]  dm_rdata;
    logic [XLEN-1:0]  pc_seq, pc_br, pc_jmp, pc_next;

    // Purpose: split the fetched word into its fields.
    always_comb begin
        instr  = imem[pc_q[MEM_AW+1:2]];
        opcode = instr[31:26];
        rs     = instr[25:21];
        rt     = instr[20:16];
        rd     = instr[15:11];
        imm    = instr[15:0];
        imm_sx = {{(XLEN-16){imm[15]}}, imm};
    end

    sc_main_dec u_main_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    sc_alu_dec u_alu_dec (
        .alu_class (ctrl.alu_class),
        .funct     (instr[5:0]),
        .alu_code  (alu_code)
    );

    sc_regfile #(.NREG(RF_N), .W(XLEN)) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (rs),
        .ra2   (rt),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .we    (rf_we),
        .wa    (rf_waddr),
        .wd    (rf_wdata)
    );

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .code (alu_code),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Purpose: operand, write-back and data-store steering.
    always_comb begin
        alu_b    = ctrl.b_from_imm ? imm_sx : rt_val;
        dm_idx   = alu_y[MEM_AW+1:2];
        dm_we    = ctrl.mem_we;
        dm_wdata = rt_val;
        dm_rdata = ctrl.mem_re ? dmem[dm_idx] : '0;
        rf_we    = ctrl.reg_we;
        rf_waddr = ctrl.dst_is_rd ? rd : rt;
        rf_wdata = ctrl.wb_from_mem ? dm_rdata : alu_y;
        dbg_data = dmem[dbg_addr];
    end

    // Purpose: next-address choice among sequential, branch and jump.
    always_comb begin
        pc_seq = pc_q + XLEN'(4);
        pc_br  = pc_seq + {imm_sx[XLEN-3:0], 2'b00};
        pc_jmp = {pc_q[XLEN-1:XLEN-4], instr[25:0], 2'b00};
        if (ctrl.is_jump) begin
            pc_next = pc_jmp;
        end else if (ctrl.is_branch && alu_zero) begin
            pc_next = pc_br;
        end else begin
            pc_next = pc_seq;
        end
    end

    // Purpose: program counter register with synchronous reset to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    // Purpose: instruction store write through the load port.
    always_ff @(posedge clk) begin
        if (ld_we && !ld_to_data) begin
            imem[ld_addr] <= ld_data;
        end
    end

    // Purpose: data store write; the load port takes precedence over stores.
    always_ff @(posedge clk) begin
        if (ld_we && ld_to_data) begin
            dmem[ld_addr] <= ld_data;
        end else if (rst_n && dm_we) begin
            dmem[dm_idx] <= dm_wdata;
        end
    end

    assign pc = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
// Checker for sc_core: temporal properties on control flow and write
// enables, attached to every sc_core instance by the bind below.
module sc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        rf_we,
    input logic        dm_we,
    input logic [31:0] dm_wdata
);

    logic [5:0]  op;
    logic [31:0] br_tgt;
    logic        known_op;

    // Purpose: helper terms computed independently of the core's datapath.
    always_comb begin
        op       = instr[31:26];
        br_tgt   = pc + 32'd4 + {{14{instr[15]}}, instr[15:0], 2'b00};
        known_op = (op == 6'd0) || (op == 6'd2) || (op == 6'd4) ||
                   (op == 6'd35) || (op == 6'd43);
    end

    p_reset_pc_r1: assert property (@(posedge clk)
        !rst_n |=> (pc == 32'd0));

    p_seq_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 6'd2 && op != 6'd4) |=> (pc == $past(pc) + 32'd4));

    p_store_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd43) |-> (dm_we && !rf_we));

    p_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd4) |=> (pc == $past(br_tgt) || pc == $past(pc) + 32'd4));

    p_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd2) |=> (pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}));

    p_zero_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd43 && instr[20:16] == 5'd0) |-> (dm_wdata == 32'd0));

    p_undef_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !known_op |-> (!rf_we && !dm_we));

endmodule

bind sc_core sc_core_chk u_sc_core_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc       (pc_q),
    .instr    (instr),
    .rf_we    (rf_we),
    .dm_we    (dm_we),
    .dm_wdata (dm_wdata)
);

// File: tb/sc_core_test.sv
// Bench for sc_core: an instruction-level reference model steps alongside
// the core and is compared every clock on pc and a swept debug read.
module sc_core_test;

    localparam int CLK_P  = 10;
    localparam int MEM_AW = 6;
    localparam int DEPTH  = 1 << MEM_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_we = 1'b0;
    logic              ld_to_data = 1'b0;
    logic [MEM_AW-1:0] ld_addr = '0;
    logic [31:0]       ld_data = '0;
    logic [MEM_AW-1:0] dbg_addr = '0;
    logic [31:0]       dbg_data;
    logic [31:0]       pc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] prog  [DEPTH];
    logic [31:0] m_mem [DEPTH];
    logic [31:0] m_reg [32];
    logic [31:0] m_pc;

    sc_core #(.MEM_AW(MEM_AW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_we      (ld_we),
        .ld_to_data (ld_to_data),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .dbg_addr   (dbg_addr),
        .dbg_data   (dbg_data),
        .pc         (pc)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] enc_j(int tgt);
        return {6'd2, 26'(tgt)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference step: executes the instruction at m_pc, returns the tag of its class.
    task automatic model_step(output string tag);
        logic [31:0] ins, a, b, sx, addr, res;
        int op, rs, rt, rd, fn;
        bit wr;
        ins = prog[m_pc[MEM_AW+1:2]];
        op = int'(ins[31:26]); rs = int'(ins[25:21]); rt = int'(ins[20:16]);
        rd = int'(ins[15:11]); fn = int'(ins[5:0]);
        a = (rs == 0) ? 32'd0 : m_reg[rs];
        b = (rt == 0) ? 32'd0 : m_reg[rt];
        sx = {{16{ins[15]}}, ins[15:0]};
        addr = a + sx;
        tag = "R2";
        case (op)
            0: begin
                wr = 1'b1;
                case (fn)
                    32: res = a + b;
                    34: res = a - b;
                    36: res = a & b;
                    37: res = a | b;
                    42: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: res = a + b;
                endcase
                if (wr && rd != 0) m_reg[rd] = res;
                m_pc = m_pc + 4;
            end
            35: begin
                if (rt != 0) m_reg[rt] = m_mem[addr[MEM_AW+1:2]];
                m_pc = m_pc + 4;
            end
            43: begin
                m_mem[addr[MEM_AW+1:2]] = b;
                m_pc = m_pc + 4;
            end
            4: begin
                tag = "R7";
                if (a == b) m_pc = m_pc + 4 + {sx[29:0], 2'b00};
                else        m_pc = m_pc + 4;
            end
            2: begin
                tag = "R8";
                m_pc = {m_pc[31:28], ins[25:0], 2'b00};
            end
            default: begin
                tag = "R10";
                m_pc = m_pc + 4;
            end
        endcase
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        string tag;
        // Program and data image.
        for (int i = 0; i < DEPTH; i++) begin
            prog[i]  = 32'hFFFF_FFFF;
            m_mem[i] = 32'(i * 3 + 1);
        end
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_mem[0] = 32'd5;        m_mem[1] = 32'hFFFF_FFFD; m_mem[2] = 32'd5;
        m_mem[3] = 32'h0F0F_00FF; m_mem[4] = 32'h00FF_0F0F; m_mem[6] = 32'd92;
        m_mem[8] = 32'hDEAD_BEEF; m_mem[9] = 32'h1234_5678; m_mem[10] = 32'hA0A0_A0A0;
        m_mem[11] = 32'hB0B0_B0B0; m_mem[23] = 32'hC0C0_C0C0; m_mem[24] = 32'h1111_1111;
        prog[0]  = enc_i(35, 0, 1, 0);
        prog[1]  = enc_i(35, 0, 2, 4);
        prog[2]  = enc_i(35, 0, 3, 8);
        prog[3]  = enc_i(35, 0, 4, 12);
        prog[4]  = enc_i(35, 0, 5, 16);
        prog[5]  = enc_i(35, 0, 13, 24);
        prog[6]  = enc_r(1, 2, 6, 32);
        prog[7]  = enc_r(1, 2, 7, 34);
        prog[8]  = enc_r(4, 5, 8, 36);
        prog[9]  = enc_r(4, 5, 9, 37);
        prog[10] = enc_r(2, 1, 10, 42);
        prog[11] = enc_r(1, 2, 11, 42);
        prog[12] = enc_r(1, 1, 0, 32);
        prog[13] = enc_i(43, 0, 6, 64);
        prog[14] = enc_i(43, 0, 7, 68);
        prog[15] = enc_i(43, 0, 8, 72);
        prog[16] = enc_i(43, 0, 9, 76);
        prog[17] = enc_i(43, 0, 10, 80);
        prog[18] = enc_i(43, 0, 11, 84);
        prog[19] = enc_i(43, 0, 0, 32);
        prog[20] = enc_i(63, 0, 1, 36);
        prog[21] = enc_i(4, 1, 2, 5);
        prog[22] = enc_i(4, 1, 3, 2);
        prog[23] = enc_i(43, 0, 1, 40);
        prog[24] = enc_i(43, 0, 1, 44);
        prog[25] = enc_i(43, 13, 1, -4);
        prog[26] = enc_i(43, 0, 14, 96);
        prog[27] = enc_j(29);
        prog[28] = enc_i(43, 0, 1, 92);
        prog[29] = enc_i(35, 0, 15, 88);
        prog[30] = enc_i(43, 0, 15, 100);
        prog[31] = enc_i(4, 0, 0, -1);

        // Load both stores while reset is held (R11).
        for (int i = 0; i < 2 * DEPTH; i++) begin
            @(negedge clk);
            ld_we = 1'b1;
            ld_to_data = (i >= DEPTH);
            ld_addr = MEM_AW'(i % DEPTH);
            ld_data = (i >= DEPTH) ? m_mem[i - DEPTH] : prog[i];
        end
        @(negedge clk);
        ld_we = 1'b0;
        chk("R1 pc in reset", pc, 32'd0);
        for (int i = 0; i < DEPTH; i++) begin
            dbg_addr = MEM_AW'(i);
            #1;
            chk("R11 data load readback", dbg_data, m_mem[i]);
        end

        // Release reset and compare every clock.
        m_pc = 32'd0;
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 60; cyc++) begin
            @(posedge clk);
            model_step(tag);
            @(negedge clk);
            dbg_addr = MEM_AW'(cyc % DEPTH);
            #1;
            chk({tag, " pc"}, pc, m_pc);
            chk("R12 debug sweep", dbg_data, m_mem[cyc % DEPTH]);
        end

        // Result words, with hand-worked expectations.
        begin
            int          addrs [14] = '{16, 17, 18, 19, 20, 21, 8, 9, 10, 11, 22, 24, 23, 25};
            logic [31:0] exps  [14] = '{32'd2, 32'd8, 32'h000F_000F, 32'h0FFF_0FFF, 32'd1, 32'd0,
                                        32'd0, 32'h1234_5678, 32'hA0A0_A0A0, 32'hB0B0_B0B0,
                                        32'd5, 32'd0, 32'hC0C0_C0C0, 32'd5};
            string       tags  [14] = '{"R3 add", "R3 sub", "R3 and", "R3 or", "R4 slt true",
                                        "R4 slt false", "R9 zero reg", "R10 undef no store",
                                        "R7 skipped store", "R7 skipped store", "R6 negative offset",
                                        "R1 cleared reg", "R8 jumped over", "R5 load to rt"};
            for (int k = 0; k < 14; k++) begin
                dbg_addr = MEM_AW'(addrs[k]);
                #1;
                chk(tags[k], dbg_data, exps[k]);
            end
        end

        // Second reset mid-run.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 pc after reset", pc, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule